// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from a small set of external pins and a group of internal peripheral request lines, and decides when the processor is interrupted and where it goes. Every source owns a sticky request flag, an enable bit and a priority bit. The external pins pass through a two-flop synchroniser and an edge detector whose polarity is chosen per pin. The internal lines set their flag in any cycle they are high.

With the priority mode on, sources split into a high and a low group. The high group vectors to 0x000008 and the low group vectors to 0x000018. Each group has its own global enable. A high request may preempt a low service routine that is already running, but not the reverse. With the priority mode off, all sources form one group. That group uses the high vector and the high global enable.

The core raises `insn_boundary` when an instruction completes. The block then holds `irq_take`, together with the vector and the level, until the core returns `ack`. On the acknowledge, the block clears the global enable of the taken level and pushes the level onto a two-entry record. A `ret` pulse pops that record and sets the global enable of the popped level again.

Top module: `prio_intc`

## Requirements
- R1: An external pin edge sets its flag. The edge is rising when the pin's `ext_rise` bit is 1 and falling when it is 0. The opposite edge does nothing. Flags for pin i sit at `flags[i]`. The flag is set whatever the enable bit is, and it stays set until a `flag_clr` pulse on that bit clears it.
- R2: A high peripheral line j sets `flags[N_EXT+j]`, even while that source is disabled.
- R3: With `prio_mode`=1, a source whose `src_hi` bit is 1 takes vector 0x000008 with `irq_hi`=1. A source whose bit is 0 takes 0x000018 with `irq_hi`=0. When both groups are pending, the high group wins.
- R4: A take is decided only in a cycle with `insn_boundary` high. Once raised, `irq_take`, `irq_vector` and `irq_hi` stay unchanged until `ack`.
- R5: When `ack` arrives during a take, `irq_take` falls on the next cycle. The global enable of the taken level is cleared, and the level becomes the active one.
- R6: A high request preempts an active low service. A low request is never taken while a high service is active, even with both global enables set.
- R7: `ret` pops the active-level record and sets the global enable of the popped level. After a nested high service returns, the active level is low again.
- R8: With `prio_mode`=0, priority bits are ignored. Every enabled flag vectors to 0x000008 with `irq_hi`=1, gated by `gie_hi` alone.
- R9: A flag whose enable is 0, or whose level's global enable is 0, never causes a take.
- R10: After reset, all flags, both global enables, `irq_take` and `act_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | N_EXT | Asynchronous external request pins |
| ext_rise | input | N_EXT | Edge select per pin, 1 = rising, 0 = falling |
| per_req | input | N_PER | Internal peripheral request lines |
| src_en | input | N_EXT+N_PER | Per-source enable |
| src_hi | input | N_EXT+N_PER | Per-source priority, 1 = high |
| flag_clr | input | N_EXT+N_PER | Per-source flag clear pulse |
| prio_mode | input | 1 | 1 = two-level scheme, 0 = single level |
| gie_set_hi | input | 1 | Sets the high global enable |
| gie_set_lo | input | 1 | Sets the low global enable |
| insn_boundary | input | 1 | Current instruction completes this cycle |
| ack | input | 1 | Core accepts the pending take |
| ret | input | 1 | Return-from-interrupt pulse |
| flags | output | N_EXT+N_PER | Request flags |
| irq_take | output | 1 | Interrupt take request, held until ack |
| irq_vector | output | AW | Vector for the pending take |
| irq_hi | output | 1 | Level of the pending take |
| act_valid | output | 1 | A service routine is active |
| act_hi | output | 1 | Level of the innermost active service |
| gie_hi | output | 1 | High-level global enable |
| gie_lo | output | 1 | Low-level global enable |

## Verification
On every cycle, the assertions check several rules. A take rises only after an instruction boundary, stays stable until acknowledged, and drops after the acknowledge. The vector always matches the level, and a low take never appears over an active high service. They also check that an acknowledge clears the matching global enable and that a return of a low service restores the low enable. Some behaviour only the bench's scenarios can show. This covers edge polarity through the synchroniser, flags set while disabled, the high-over-low choice, the nested preempt-and-return order, and the single-level mode ignoring the low enable.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_EXT = 3,
  parameter int N_PER = 8,
  parameter int AW = 24,
  parameter logic [AW-1:0] VEC_HI = 24'h000008,
  parameter logic [AW-1:0] VEC_LO = 24'h000018,
  localparam int NS = N_EXT + N_PER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_rise,
  input  logic [N_PER-1:0] per_req,
  input  logic [NS-1:0] src_en,
  input  logic [NS-1:0] src_hi,
  input  logic [NS-1:0] flag_clr,
  input  logic          prio_mode,
  input  logic          gie_set_hi,
  input  logic          gie_set_lo,
  input  logic          insn_boundary,
  input  logic          ack,
  input  logic          ret,
  output logic [NS-1:0] flags,
  output logic          irq_take,
  output logic [AW-1:0] irq_vector,
  output logic          irq_hi,
  output logic          act_valid,
  output logic          act_hi,
  output logic          gie_hi,
  output logic          gie_lo
);

  logic [N_EXT-1:0] sync1, sync2, prev;
  logic [N_EXT-1:0] ext_evt;
  logic [NS-1:0]    live;
  logic [1:0]       depth;
  logic [1:0]       lvl;
  logic             hi_live, lo_live, room, top_hi;
  logic             want_hi, want_lo, pop_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= ext_pin;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign ext_evt = (ext_rise & sync2 & ~prev) | (~ext_rise & ~sync2 & prev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | {per_req, ext_evt};

  assign live    = flags & src_en;
  assign hi_live = prio_mode ? |(live & src_hi) : |live;
  assign lo_live = prio_mode & |(live & ~src_hi);

  assign act_valid = depth != 2'd0;
  assign act_hi    = (depth == 2'd2) ? lvl[1] : (lvl[0] & act_valid);
  assign top_hi    = act_valid & act_hi;
  assign room      = depth != 2'd2;
  assign pop_hi    = act_hi;

  assign want_hi = hi_live & gie_hi & room;
  assign want_lo = lo_live & gie_lo & gie_hi & room & ~top_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_take <= 1'b0;
      irq_hi   <= 1'b0;
    end else if (irq_take) begin
      if (ack) irq_take <= 1'b0;
    end else if (insn_boundary && (want_hi || want_lo)) begin
      irq_take <= 1'b1;
      irq_hi   <= want_hi;
    end

  assign irq_vector = irq_hi ? VEC_HI : VEC_LO;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      depth <= 2'd0;
      lvl   <= 2'b00;
    end else if (irq_take && ack) begin
      if (depth == 2'd0) lvl[0] <= irq_hi;
      else               lvl[1] <= irq_hi;
      depth <= depth + 2'd1;
    end else if (ret && act_valid) begin
      depth <= depth - 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gie_hi <= 1'b0;
      gie_lo <= 1'b0;
    end else begin
      if (gie_set_hi) gie_hi <= 1'b1;
      if (gie_set_lo) gie_lo <= 1'b1;
      if (irq_take && ack) begin
        if (irq_hi) gie_hi <= 1'b0;
        else        gie_lo <= 1'b0;
      end else if (ret && act_valid) begin
        if (pop_hi) gie_hi <= 1'b1;
        else        gie_lo <= 1'b1;
      end
    end

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int AW = 24,
  parameter logic [AW-1:0] VEC_HI = 24'h000008,
  parameter logic [AW-1:0] VEC_LO = 24'h000018
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic          ack,
  input logic          ret,
  input logic          gie_set_hi,
  input logic          gie_set_lo,
  input logic          irq_take,
  input logic [AW-1:0] irq_vector,
  input logic          irq_hi,
  input logic          act_valid,
  input logic          act_hi,
  input logic          gie_hi,
  input logic          gie_lo
);

  p_take_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_take) |-> $past(insn_boundary));

  p_take_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && !ack |=> irq_take && $stable(irq_vector) && $stable(irq_hi));

  p_take_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && ack |=> !irq_take);

  p_ack_clr_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && ack && irq_hi && !gie_set_hi |=> !gie_hi);

  p_ack_clr_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && ack && !irq_hi && !gie_set_lo |=> !gie_lo);

  p_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_vector == (irq_hi ? VEC_HI : VEC_LO));

  p_no_lo_over_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_take) && !irq_hi |-> !$past(act_valid && act_hi));

  p_ret_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !(irq_take && ack) && act_valid && !act_hi |=> gie_lo);

endmodule

bind prio_intc prio_intc_chk #(.AW(AW), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .ack(ack), .ret(ret),
  .gie_set_hi(gie_set_hi), .gie_set_lo(gie_set_lo), .irq_take(irq_take),
  .irq_vector(irq_vector), .irq_hi(irq_hi), .act_valid(act_valid), .act_hi(act_hi),
  .gie_hi(gie_hi), .gie_lo(gie_lo)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int N_EXT = 3;
  localparam int N_PER = 8;
  localparam int NS = N_EXT + N_PER;

  logic clk = 0, rst_n = 0;
  logic [N_EXT-1:0] ext_pin = '0, ext_rise = '0;
  logic [N_PER-1:0] per_req = '0;
  logic [NS-1:0] src_en = '0, src_hi = '0, flag_clr = '0;
  logic prio_mode = 0, gie_set_hi = 0, gie_set_lo = 0;
  logic insn_boundary = 0, ack = 0, ret = 0;
  logic [NS-1:0] flags;
  logic irq_take, irq_hi, act_valid, act_hi, gie_hi, gie_lo;
  logic [23:0] irq_vector;

  int checks = 0, errors = 0;
  bit done = 0;

  prio_intc i_prio_intc (.*);

  always #10 clk = ~clk;

  // {mode, en[7:0], hi[7:0], req[7:0], exp_take, exp_hi} over peripheral sources
  localparam logic [26:0] TBL [8] = '{
    {1'b1, 8'h01, 8'h01, 8'h01, 1'b1, 1'b1},
    {1'b1, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0},
    {1'b1, 8'h03, 8'h02, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0},
    {1'b1, 8'hF0, 8'h00, 8'h0F, 1'b0, 1'b0},
    {1'b0, 8'h01, 8'h00, 8'h01, 1'b1, 1'b1},
    {1'b0, 8'h80, 8'h80, 8'h80, 1'b1, 1'b1},
    {1'b1, 8'h80, 8'h00, 8'h80, 1'b1, 1'b0}
  };

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_boundary();
    insn_boundary = 1; tick(); insn_boundary = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_ret();
    ret = 1; tick(); ret = 0;
  endtask

  task automatic clear_all();
    flag_clr = '1; tick(); flag_clr = '0;
  endtask

  task automatic set_gie(bit h, bit l);
    gie_set_hi = h; gie_set_lo = l; tick(); gie_set_hi = 0; gie_set_lo = 0;
  endtask

  task automatic raise_per(logic [N_PER-1:0] r);
    per_req = r; tick(); per_req = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R10 reset state
    chk("R10 flags", int'(flags), 0);
    chk("R10 take", int'(irq_take), 0);
    chk("R10 gie", int'({gie_hi, gie_lo}), 0);
    chk("R10 active", int'(act_valid), 0);

    // R1 edge select, sticky flags with enable off
    ext_rise = 3'b101;
    ext_pin = 3'b010; tick(6);
    chk("R1 wrong edge ignored", int'(flags[2:0]), 0);
    ext_pin = 3'b001; tick(6);
    chk("R1 rising and falling edges", int'(flags[2:0]), 3'b011);
    tick(5);
    chk("R1 flag holds", int'(flags[2:0]), 3'b011);
    flag_clr = 11'b001; tick(); flag_clr = '0;
    chk("R1 clear one flag", int'(flags[2:0]), 3'b010);
    clear_all();

    // R9 global enables clear after reset block takes
    prio_mode = 1; src_en = 11'h008; src_hi = 11'h008;
    raise_per(8'h01); tick(); pulse_boundary();
    chk("R9 gie off no take", int'(irq_take), 0);
    clear_all();

    // table-driven vectors
    for (int k = 0; k < 8; k++) begin
      logic [26:0] e;
      e = TBL[k];
      clear_all();
      prio_mode = e[26];
      src_en = {e[25:18], 3'b000};
      src_hi = {e[17:10], 3'b000};
      set_gie(1, 1);
      raise_per(e[9:2]);
      chk("R2 flags from peripheral lines", int'(flags[10:3]), int'(e[9:2]));
      tick();
      pulse_boundary();
      chk(e[26] ? "R3/R9 take" : "R8 take", int'(irq_take), int'(e[1]));
      if (e[1]) begin
        chk(e[26] ? "R3 level" : "R8 level", int'(irq_hi), int'(e[0]));
        chk(e[26] ? "R3 vector" : "R8 vector", int'(irq_vector), e[0] ? 'h08 : 'h18);
        do_ack();
        do_ret();
      end
      chk("R7 record empty", int'(act_valid), 0);
    end
    clear_all();

    // R4 boundary-only sampling and hold until ack; R5 ack effects
    prio_mode = 1; src_en = 11'h008; src_hi = 11'h008;
    set_gie(1, 1);
    raise_per(8'h01);
    tick(3);
    chk("R4 no boundary no take", int'(irq_take), 0);
    pulse_boundary();
    tick(3);
    chk("R4 take held", int'(irq_take), 1);
    chk("R4 vector held", int'(irq_vector), 'h08);
    do_ack();
    chk("R5 take drops", int'(irq_take), 0);
    chk("R5 gie_hi cleared", int'(gie_hi), 0);
    chk("R5 active level high", int'({act_valid, act_hi}), 3);
    do_ret();
    chk("R7 gie_hi restored", int'(gie_hi), 1);
    clear_all();

    // R6/R7 nesting: low taken, high preempts, low blocked under high
    src_en = 11'h018; src_hi = 11'h010;
    set_gie(1, 1);
    raise_per(8'h01); tick(); pulse_boundary();
    chk("R6 low taken", int'(irq_vector), 'h18);
    do_ack();
    chk("R5 gie_lo cleared", int'(gie_lo), 0);
    raise_per(8'h02); tick(); pulse_boundary();
    chk("R6 high preempts low", int'({irq_take, irq_hi}), 3);
    do_ack();
    chk("R6 active high nested", int'({act_valid, act_hi}), 3);
    set_gie(1, 1);
    flag_clr = 11'h010; tick(); flag_clr = '0;
    pulse_boundary();
    chk("R6 low blocked under high", int'(irq_take), 0);
    gie_set_hi = 0;
    do_ret();
    chk("R7 back to low level", int'({act_valid, act_hi}), 2);
    clear_all();
    do_ret();
    chk("R7 low return sets gie_lo", int'({act_valid, gie_lo}), 1);

    // R8 single level ignores gie_lo
    do_ret();
    src_en = 11'h008; src_hi = 11'h000; prio_mode = 0;
    raise_per(8'h01);
    src_en = 11'h000; set_gie(1, 0); src_en = 11'h008;
    raise_per(8'h01);
    // gie_hi now 1: clear it by one take then test with gie_lo only
    tick(); pulse_boundary(); do_ack();
    chk("R8 single level clears gie_hi", int'(gie_hi), 0);
    do_ret();
    chk("R7 single return sets gie_hi", int'(gie_hi), 1);
    pulse_boundary(); do_ack();
    set_gie(0, 1);
    tick(); pulse_boundary();
    chk("R8 gie_lo alone no take", int'(irq_take), 0);
    do_ret();
    pulse_boundary();
    chk("R8 vector single level", int'({irq_take, irq_hi, irq_vector}), {2'b11, 24'h08});
    do_ack(); do_ret();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule